// File: doc/BRIEF.md
# Two-Winding Stepper Chopper Controller

This block is the digital core that runs two full bridges, one per winding of a bipolar stepper motor. For each winding it takes a direction bit, a two-bit current-level code and a trip signal from an external current comparator. From these it produces the four switch enables of that bridge and a two-bit threshold select that tells the comparator which current limit to apply. A shared oscillator tick sets a fixed chopping period. The bridge of winding A starts its period at the wrap of the oscillator counter. The bridge of winding B starts half a period later, so the two bridges never turn on at the same instant.

Inside a period a bridge drives its diagonal (one high-side and the opposite low-side switch) until the comparator trips. After a trip it opens the low side and lets the winding current recirculate through the high side (slow decay) until the next period start. A change of direction opens all four switches of that bridge for a programmable dead time, so the current decays fast, and only then enables the new diagonal. When every level bit of both windings is zero, the block enters a low-power inhibit state. It leaves inhibit only at a winding-A period boundary.

The bridge sequencer of each winding has four states: OFF, DEAD, DRIVE and DECAY. Its transitions are:
- disable: any state to OFF when the level code is 00 or inhibit is active.
- start: OFF to DRIVE on a period start with no direction change.
- reverse: DRIVE, DECAY or DEAD to DEAD on a direction change; in DEAD this restarts the count.
- release: DEAD to DRIVE when the dead count expires.
- rearm: DRIVE to DRIVE on a period start; this restarts blanking.
- trip: DRIVE to DECAY on a trip once blanking has elapsed.
- recharge: DECAY to DRIVE on a period start.

The inhibit sequencer has three states: SLEEP, WAKE and RUN. Its transitions are:
- wake: SLEEP to WAKE when any level bit is set.
- resume: WAKE to RUN on a winding-A period start.
- sleep: WAKE or RUN to SLEEP when all level bits are zero.

Top module: `stepper_bridge_ctrl`

## Requirements
- R1: After reset, all eight switch enables are 0 and `inhibit_o` is 1.
- R2: `thr_sel_o` equals `level_i` at all times. Winding A uses bits [1:0] and winding B uses bits [3:2]. The codes are 00 = no current, 01 = hold, 10 = normal, 11 = accelerate.
- R3: One clock after all four `level_i` bits are 0, `inhibit_o` is 1 and all switch enables are 0. They stay so while the bits remain 0.
- R4: After a nonzero level code appears, `inhibit_o` drops only on the clock after a winding-A period start. Both bridges are still fully off in the first cycle with `inhibit_o` = 0.
- R5: Each bridge's enables are 4 bits {low2, low1, high2, high1}; winding A is `gates_o[3:0]` and winding B is `gates_o[7:4]`. While driving, direction 1 gives 1001 and direction 0 gives 0110. High and low of the same leg are never both on.
- R6: The oscillator counts `OSC_STEPS` ticks per period. Winding A starts its period at the counter wrap, and winding B starts `OSC_STEPS/2` ticks later.
- R7: A trip, seen two clocks later through the synchronizer, turns the low side off until the next period start of that winding. The high side stays on, giving 0001 for direction 1 and 0010 for direction 0.
- R8: A trip is ignored during the first `BLANK_CYC` clocks of a drive interval. With the trip held high, the low side is on for exactly `BLANK_CYC`+1 clocks per period.
- R9: A change of a winding's direction while its bridge is active opens all four switches of that bridge for `DEAD_CYC` clocks. The bridge then drives the new diagonal. A further change during the dead time restarts the count, and the other bridge is not affected.
- R10: A winding whose level code is 00 keeps its bridge at 0000 while the other winding runs, and its direction changes have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator tick, one clock wide |
| dir_i | input | 2 | Direction per winding (bit 0 = A, bit 1 = B) |
| level_i | input | 4 | Current-level code, A in [1:0], B in [3:2] |
| trip_i | input | 2 | Asynchronous comparator trip per winding |
| gates_o | output | 8 | Switch enables, {low2,low1,high2,high1} per bridge, A in [3:0] |
| thr_sel_o | output | 4 | Comparator threshold select per winding |
| inhibit_o | output | 1 | Inhibit status |

## Verification
The bench builds the block with `OSC_STEPS` = 8, `DEAD_CYC` = 6 and `BLANK_CYC` = 2, and drives a tick on every second clock, so one chopping period is 16 clocks. With these values the winding-B offset of 8 clocks, the three-clock minimum drive and the six-clock dead time can all be measured exactly. A period boundary, an inhibit wake-up and a restarted dead time each fit into a few dozen clocks. A long randomized stretch then mixes direction glitches, trips and level changes that land at every point of the period.

// File: rtl/stepper_pkg.sv
`timescale 1ns/1ps
package stepper_pkg;

    localparam int unsigned NUM_PHASES   = 2;
    localparam int unsigned GATES_PER_BR = 4;

    // gate bit positions inside one bridge nibble
    localparam int unsigned G_HIGH1 = 0;
    localparam int unsigned G_HIGH2 = 1;
    localparam int unsigned G_LOW1  = 2;
    localparam int unsigned G_LOW2  = 3;

    typedef enum logic [1:0] {
        BR_OFF   = 2'd0,
        BR_DEAD  = 2'd1,
        BR_DRIVE = 2'd2,
        BR_DECAY = 2'd3
    } br_state_t;

    typedef enum logic [1:0] {
        INH_SLEEP = 2'd0,
        INH_WAKE  = 2'd1,
        INH_RUN   = 2'd2
    } inh_state_t;

endpackage

// File: rtl/stepper_sync2.sv
`timescale 1ns/1ps
module stepper_sync2 #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/stepper_chop_osc.sv
`timescale 1ns/1ps
module stepper_chop_osc #(
    parameter int unsigned OSC_STEPS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    output logic start_a_o,
    output logic start_b_o
);

    localparam int unsigned CW = (OSC_STEPS < 3) ? 1 : $clog2(OSC_STEPS);
    localparam logic [CW-1:0] LAST_V = CW'(OSC_STEPS - 1);
    localparam logic [CW-1:0] HALF_V = CW'(OSC_STEPS / 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (osc_tick) begin
            if (cnt_q == '0) begin
                cnt_q <= LAST_V;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    // winding A starts at the wrap, winding B half a period later
    assign start_a_o = osc_tick && (cnt_q == '0);
    assign start_b_o = osc_tick && (cnt_q == HALF_V);

endmodule

// File: rtl/stepper_inhibit_fsm.sv
`timescale 1ns/1ps
module stepper_inhibit_fsm
    import stepper_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_level_i,
    input  logic start_a_i,
    output logic inhibit_o
);

    inh_state_t st_q;
    inh_state_t st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= INH_SLEEP;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            INH_SLEEP: begin
                if (any_level_i) st_d = INH_WAKE;
            end
            INH_WAKE: begin
                if (!any_level_i)   st_d = INH_SLEEP;
                else if (start_a_i) st_d = INH_RUN;
            end
            INH_RUN: begin
                if (!any_level_i) st_d = INH_SLEEP;
            end
            default: st_d = INH_SLEEP;
        endcase
    end

    always_comb begin
        inhibit_o = (st_q != INH_RUN);
    end

endmodule

// File: rtl/stepper_bridge_fsm.sv
`timescale 1ns/1ps
module stepper_bridge_fsm
    import stepper_pkg::*;
#(
    parameter int unsigned DEAD_CYC  = 16,
    parameter int unsigned BLANK_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dir_i,
    input  logic [1:0]              level_i,
    input  logic                    trip_i,
    input  logic                    period_i,
    input  logic                    hold_off_i,
    output logic [GATES_PER_BR-1:0] gates_o
);

    localparam int unsigned DW = (DEAD_CYC < 3) ? 1 : $clog2(DEAD_CYC);
    localparam int unsigned OW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);
    localparam logic [DW-1:0] DEAD_RELOAD = DW'(DEAD_CYC - 1);
    localparam logic [OW-1:0] BLANK_V     = OW'(BLANK_CYC);

    br_state_t     st_q;
    br_state_t     st_d;
    logic [DW-1:0] dead_q;
    logic [DW-1:0] dead_d;
    logic [OW-1:0] on_q;
    logic [OW-1:0] on_d;
    logic          dir_q;
    logic          dir_edge;
    logic          run_ok;

    assign dir_edge = (dir_i != dir_q);
    assign run_ok   = (level_i != 2'b00) && !hold_off_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= BR_OFF;
            dead_q <= '0;
            on_q   <= '0;
            dir_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            dead_q <= dead_d;
            on_q   <= on_d;
            dir_q  <= dir_i;
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        dead_d = dead_q;
        on_d   = on_q;
        if (!run_ok) begin
            st_d = BR_OFF;
        end else begin
            unique case (st_q)
                BR_OFF: begin
                    if (period_i && !dir_edge) begin
                        st_d = BR_DRIVE;
                        on_d = '0;
                    end
                end
                BR_DEAD: begin
                    if (dir_edge) begin
                        dead_d = DEAD_RELOAD;
                    end else if (dead_q == '0) begin
                        st_d = BR_DRIVE;
                        on_d = '0;
                    end else begin
                        dead_d = dead_q - DW'(1);
                    end
                end
                BR_DRIVE: begin
                    if (dir_edge) begin
                        st_d   = BR_DEAD;
                        dead_d = DEAD_RELOAD;
                    end else if (period_i) begin
                        on_d = '0;
                    end else if (trip_i && (on_q == BLANK_V)) begin
                        st_d = BR_DECAY;
                    end else if (on_q != BLANK_V) begin
                        on_d = on_q + OW'(1);
                    end
                end
                BR_DECAY: begin
                    if (dir_edge) begin
                        st_d   = BR_DEAD;
                        dead_d = DEAD_RELOAD;
                    end else if (period_i) begin
                        st_d = BR_DRIVE;
                        on_d = '0;
                    end
                end
                default: st_d = BR_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        gates_o = '0;
        unique case (st_q)
            BR_DRIVE: begin
                if (dir_q) begin
                    gates_o[G_HIGH1] = 1'b1;
                    gates_o[G_LOW2]  = 1'b1;
                end else begin
                    gates_o[G_HIGH2] = 1'b1;
                    gates_o[G_LOW1]  = 1'b1;
                end
            end
            BR_DECAY: begin
                if (dir_q) gates_o[G_HIGH1] = 1'b1;
                else       gates_o[G_HIGH2] = 1'b1;
            end
            BR_OFF, BR_DEAD: gates_o = '0;
            default: gates_o = '0;
        endcase
    end

endmodule

// File: rtl/stepper_bridge_ctrl.sv
`timescale 1ns/1ps
module stepper_bridge_ctrl
    import stepper_pkg::*;
#(
    parameter int unsigned OSC_STEPS = 8,
    parameter int unsigned DEAD_CYC  = 16,
    parameter int unsigned BLANK_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic [1:0] dir_i,
    input  logic [3:0] level_i,
    input  logic [1:0] trip_i,
    output logic [7:0] gates_o,
    output logic [3:0] thr_sel_o,
    output logic       inhibit_o
);

    logic [NUM_PHASES-1:0] trip_sync;
    logic [NUM_PHASES-1:0] period_start;
    logic                  start_a;
    logic                  start_b;
    logic                  hold_off;

    stepper_sync2 #(.WIDTH(NUM_PHASES)) u_trip_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (trip_i),
        .sync_o  (trip_sync)
    );

    stepper_chop_osc #(.OSC_STEPS(OSC_STEPS)) u_osc (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .start_a_o (start_a),
        .start_b_o (start_b)
    );

    stepper_inhibit_fsm u_inhibit (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_level_i (|level_i),
        .start_a_i   (start_a),
        .inhibit_o   (hold_off)
    );

    assign period_start = {start_b, start_a};
    assign inhibit_o    = hold_off;
    assign thr_sel_o    = level_i;

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_bridge
        stepper_bridge_fsm #(
            .DEAD_CYC  (DEAD_CYC),
            .BLANK_CYC (BLANK_CYC)
        ) u_bridge (
            .clk        (clk),
            .rst_n      (rst_n),
            .dir_i      (dir_i[p]),
            .level_i    (level_i[2*p +: 2]),
            .trip_i     (trip_sync[p]),
            .period_i   (period_start[p]),
            .hold_off_i (hold_off),
            .gates_o    (gates_o[GATES_PER_BR*p +: GATES_PER_BR])
        );
    end

endmodule

// File: rtl/stepper_bridge_ctrl_chk.sv
`timescale 1ns/1ps
module stepper_bridge_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] dir_i,
    input logic [7:0] gates_o,
    input logic       inhibit_o
);

    // R3: inhibit keeps every switch open
    assert_inhibit_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_o |-> (gates_o == 8'h00));

    for (genvar p = 0; p < 2; p++) begin : g_chk
        // R5: never high and low of one leg together
        assert_leg_safe_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(gates_o[4*p+0] && gates_o[4*p+2]) && !(gates_o[4*p+1] && gates_o[4*p+3]));

        // R9: a direction change opens the bridge on the next cycle
        assert_dead_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (dir_i[p] != $past(dir_i[p])) |=> (gates_o[4*p +: 4] == 4'h0));

        // R8: a low side that turns on stays on through blanking unless the bridge opens
        assert_blank_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gates_o[4*p+2] || gates_o[4*p+3]) |=>
                ((gates_o[4*p+2] || gates_o[4*p+3]) || (gates_o[4*p +: 4] == 4'h0)));

        assert_blank_hold2_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gates_o[4*p+2] || gates_o[4*p+3]) |-> ##2
                ((gates_o[4*p+2] || gates_o[4*p+3]) || (gates_o[4*p +: 4] == 4'h0)));
    end

endmodule

bind stepper_bridge_ctrl stepper_bridge_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_i     (dir_i),
    .gates_o   (gates_o),
    .inhibit_o (inhibit_o)
);

// File: tb/stepper_bridge_ctrl_bench.sv
`timescale 1ns/1ps
module stepper_bridge_ctrl_bench;

    localparam int STEPS = 8;
    localparam int DEAD  = 6;
    localparam int BLANK = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [1:0] dir_i = 2'b00;
    logic [3:0] level_i = 4'h0;
    logic [1:0] trip_i = 2'b00;
    logic [7:0] gates_o;
    logic [3:0] thr_sel_o;
    logic       inhibit_o;

    int checks = 0;
    int failures = 0;
    bit tick_run = 1'b1;
    bit tick_rand = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    stepper_bridge_ctrl #(
        .OSC_STEPS (STEPS),
        .DEAD_CYC  (DEAD),
        .BLANK_CYC (BLANK)
    ) u_stepper_bridge_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .dir_i     (dir_i),
        .level_i   (level_i),
        .trip_i    (trip_i),
        .gates_o   (gates_o),
        .thr_sel_o (thr_sel_o),
        .inhibit_o (inhibit_o)
    );

    // ---------------- reference model ----------------
    // mode per winding: 0 off, 1 dead, 2 drive, 3 decay
    int m_mode [2];
    int m_dead [2];
    int m_age  [2];
    int m_dq   [2];
    int m_t1   [2];
    int m_t2   [2];
    int m_cnt;
    int m_wake;   // 0 sleep, 1 waiting for boundary, 2 running
    bit sa, sb, nz, blocked, ps, chg, ok;
    int lv, tr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin
                m_mode[p] = 0; m_dead[p] = 0; m_age[p] = 0;
                m_dq[p] = 0; m_t1[p] = 0; m_t2[p] = 0;
            end
            m_cnt = 0;
            m_wake = 0;
        end else begin
            sa = osc_tick && (m_cnt == 0);
            sb = osc_tick && (m_cnt == STEPS / 2);
            nz = (level_i != 4'h0);
            blocked = (m_wake != 2);
            for (int p = 0; p < 2; p++) begin
                lv  = (p == 0) ? int'(level_i[1:0]) : int'(level_i[3:2]);
                ps  = (p == 0) ? sa : sb;
                chg = (int'(dir_i[p]) != m_dq[p]);
                ok  = (lv != 0) && !blocked;
                tr  = m_t2[p];
                if (!ok) m_mode[p] = 0;
                else if (m_mode[p] == 0) begin
                    if (ps && !chg) begin m_mode[p] = 2; m_age[p] = 0; end
                end else if (chg) begin
                    m_mode[p] = 1; m_dead[p] = DEAD - 1;
                end else if (m_mode[p] == 1) begin
                    if (m_dead[p] == 0) begin m_mode[p] = 2; m_age[p] = 0; end
                    else m_dead[p] = m_dead[p] - 1;
                end else if (m_mode[p] == 2) begin
                    if (ps) m_age[p] = 0;
                    else if (tr != 0 && m_age[p] >= BLANK) m_mode[p] = 3;
                    else m_age[p] = m_age[p] + 1;
                end else begin
                    if (ps) begin m_mode[p] = 2; m_age[p] = 0; end
                end
                m_dq[p] = int'(dir_i[p]);
                m_t2[p] = m_t1[p];
                m_t1[p] = int'(trip_i[p]);
            end
            if (m_wake == 0) begin
                if (nz) m_wake = 1;
            end else if (m_wake == 1) begin
                if (!nz) m_wake = 0;
                else if (sa) m_wake = 2;
            end else if (!nz) m_wake = 0;
            if (osc_tick) m_cnt = (m_cnt == 0) ? STEPS - 1 : m_cnt - 1;
        end
    end

    function automatic logic [3:0] model_gates(int p);
        if (m_mode[p] == 2) return (m_dq[p] != 0) ? 4'b1001 : 4'b0110;
        if (m_mode[p] == 3) return (m_dq[p] != 0) ? 4'b0001 : 4'b0010;
        return 4'b0000;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        if (rst_n) begin
            chk(gates_o[3:0] == model_gates(0), "R5,R6,R7,R8,R9 gates winding A",
                int'(gates_o[3:0]), int'(model_gates(0)));
            chk(gates_o[7:4] == model_gates(1), "R5,R6,R7,R8,R9,R10 gates winding B",
                int'(gates_o[7:4]), int'(model_gates(1)));
            chk(inhibit_o == (m_wake != 2), "R3,R4 inhibit status",
                int'(inhibit_o), int'(m_wake != 2));
            chk(thr_sel_o == level_i, "R2 threshold select",
                int'(thr_sel_o), int'(level_i));
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
        if (tick_rand) osc_tick = 1'($urandom_range(0, 1));
        else if (tick_run) osc_tick = ~osc_tick;
        else osc_tick = 1'b0;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    function automatic bit low_on(int p);
        return gates_o[4*p+2] || gates_o[4*p+3];
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- directed and random stimulus ----------------
    initial begin
        int found, ta, tb, tn, run, zeros;
        bit prev_a, prev_b;
        steps(4);
        rst_n = 1'b1;
        step();

        // R1: reset state
        chk(gates_o == 8'h00, "R1 gates after reset", int'(gates_o), 0);
        chk(inhibit_o == 1'b1, "R1 inhibit after reset", int'(inhibit_o), 1);

        // R3: all codes zero keeps inhibit
        steps(20);
        chk(inhibit_o == 1'b1 && gates_o == 8'h00, "R3 idle inhibit", int'({inhibit_o, gates_o}), 'h100);

        // R4, R5, R10: wake with only winding A enabled
        dir_i = 2'b01;
        level_i = 4'b0010;
        trip_i = 2'b00;
        step();
        chk(inhibit_o == 1'b1, "R4 inhibit held until boundary", int'(inhibit_o), 1);
        found = 0;
        for (int i = 0; i < 40 && !found; i++) begin
            step();
            if (!inhibit_o) found = 1;
        end
        chk(found == 1, "R4 inhibit released", found, 1);
        chk(gates_o == 8'h00, "R4 bridges off on release cycle", int'(gates_o), 0);
        found = 0;
        for (int i = 0; i < 40 && !found; i++) begin
            step();
            if (gates_o[3:0] != 4'h0) found = 1;
        end
        chk(gates_o[3:0] == 4'b1001, "R5 direction 1 diagonal", int'(gates_o[3:0]), 'b1001);
        for (int i = 0; i < 30; i++) begin
            if (i == 10) dir_i[1] = ~dir_i[1];
            step();
            chk(gates_o[7:4] == 4'h0, "R10 idle winding stays open", int'(gates_o[7:4]), 0);
        end
        dir_i[1] = 1'b0;

        // R2: threshold select follows the code
        level_i = 4'b0111;
        step();
        chk(thr_sel_o == 4'b0111, "R2 threshold 11/01", int'(thr_sel_o), 'b0111);

        // R6, R7, R8: both active, trips held high
        level_i = 4'b1010;
        dir_i = 2'b11;
        trip_i = 2'b11;
        steps(40);
        ta = -1; tb = -1; tn = -1; run = 0;
        prev_a = low_on(0); prev_b = low_on(1);
        for (int i = 0; i < 80; i++) begin
            step();
            if (low_on(0) && !prev_a) begin
                if (ta < 0) ta = i; else if (tn < 0) tn = i;
            end
            if (low_on(1) && !prev_b && ta >= 0 && tb < 0) tb = i;
            if (ta >= 0 && tn < 0) begin
                if (low_on(0)) run++;
                else chk(gates_o[3:0] == 4'b0001, "R7 slow decay keeps high side", int'(gates_o[3:0]), 'b0001);
            end
            prev_a = low_on(0); prev_b = low_on(1);
        end
        chk(tn - ta == 2 * STEPS, "R6 winding A period", tn - ta, 2 * STEPS);
        chk(tb - ta == STEPS, "R6 winding B half-period offset", tb - ta, STEPS);
        chk(run == BLANK + 1, "R8 blanked drive length", run, BLANK + 1);

        // R9: dead time and restart
        trip_i = 2'b00;
        steps(40);
        chk(gates_o == 8'h99, "R9 both driving before reversal", int'(gates_o), 'h99);
        dir_i[0] = 1'b0;
        zeros = 0;
        found = 0;
        for (int i = 0; i < 40 && !found; i++) begin
            step();
            if (gates_o[3:0] == 4'h0) zeros++; else found = 1;
            chk(gates_o[7:4] == 4'b1001, "R9 other bridge unaffected", int'(gates_o[7:4]), 'b1001);
        end
        chk(zeros == DEAD, "R9 dead time length", zeros, DEAD);
        chk(gates_o[3:0] == 4'b0110, "R9 new diagonal", int'(gates_o[3:0]), 'b0110);
        dir_i[0] = 1'b1;
        steps(3);
        dir_i[0] = 1'b0;
        zeros = 3;
        found = 0;
        for (int i = 0; i < 40 && !found; i++) begin
            step();
            if (gates_o[3:0] == 4'h0) zeros++; else found = 1;
        end
        chk(zeros == 3 + DEAD, "R9 restarted dead time", zeros, 3 + DEAD);
        chk(gates_o[3:0] == 4'b0110, "R9 diagonal after glitch", int'(gates_o[3:0]), 'b0110);

        // R3: drop all codes while running
        level_i = 4'h0;
        step();
        chk(inhibit_o == 1'b1 && gates_o == 8'h00, "R3 enter inhibit while running",
            int'({inhibit_o, gates_o}), 'h100);

        // randomized mix, compared against the model each clock
        tick_rand = 1'b1;
        level_i = 4'b1110;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 29) == 0) dir_i[0] = ~dir_i[0];
            if ($urandom_range(0, 29) == 0) dir_i[1] = ~dir_i[1];
            if ($urandom_range(0, 199) == 0) level_i = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 399) == 0) level_i = 4'h0;
            trip_i = 2'($urandom_range(0, 3));
            step();
        end
        tick_rand = 1'b0;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule